// File: doc/BRIEF.md
# Harvard 8-bit core with one branch delay slot

This block is a small 8-bit processor core with separate program and data spaces. Every cycle it reads one 16-bit word from a read-only program memory. It latches that word and executes it one cycle later. The word fetched while a branch executes therefore always runs before control reaches the branch target, so the core has exactly one delay slot.

The core holds an accumulator, a RAM page register Y, an index register X, a 16-bit program counter and an output register. X counts up by itself when the indexed addressing mode is used. The operations are:

- load (pass-through),
- OR with the accumulator,
- store to data RAM,
- near branch (to an immediate or to the accumulator),
- far jump (page taken from Y).

Because the delay slot always executes, a near branch to the accumulator whose delay slot branches back lands on one arbitrary program word for a single cycle. That word's operand byte can then be picked up as data. In this way a table kept in program memory can be read at a computed offset.

The data RAM port is read combinationally and written on the clock edge. The output port is the output register.

Top module: `h8_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the program address is 0x0000, the output port is 0x00 and no RAM write is issued; the instruction register holds a no-op word (0xE000).
- R2: With no branch executing, the program address increases by one every cycle, and each fetched word executes in the following cycle.
- R3: A word is {op[15:13], dst[12:11], idx[10], src[9:8], imm[7:0]}. The op codes are 0 load, 1 OR, 2 store, 3 far jump, 4 near branch, and 5 to 7 no-op. The dst codes are 0 AC, 1 X, 2 Y, 3 OUT. The src codes are 0 immediate, 1 RAM, 2 AC, 3 zero. A load copies the selected source byte unchanged into dst.
- R4: An OR writes (source OR AC) into dst; with dst OUT the value appears on the output port.
- R5: A store writes the source byte to RAM. The address is {0x00, imm} when idx is 0 and {Y, X} when idx is 1; a load or OR with src RAM reads from the same address.
- R6: In indexed mode, a store or a RAM-sourced load or OR increments X by one after the access. X wraps from 0xFF to 0x00 and Y is left unchanged. A load or OR whose dst is X takes priority over the increment.
- R7: The word after any branch or jump always executes, and the word after that delay slot does not.
- R8: A near branch goes to {page of the delay-slot word, source byte}; with src AC it goes to the accumulator's offset.
- R9: A far jump goes to {Y, source byte}.
- R10: A near branch to AC whose delay slot branches back into the caller's sequence executes the load-immediate at offset AC of that page. Its immediate byte is then in the accumulator, and a far jump returns control to the caller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_addr | output | 16 | Program memory read address (the program counter) |
| prog_data | input | 16 | Program word at prog_addr, same cycle |
| ram_addr | output | 16 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write byte |
| ram_we | output | 1 | Data RAM write enable, written on the rising edge |
| ram_rdata | input | 8 | Data RAM read byte at ram_addr, same cycle |
| out_port | output | 8 | Output register |

## Verification
One program runs the core through four groups of patterns:

- **Straight-line loads, ORs and stores.** Immediates and RAM operands pass through both address modes. This separates a load from an OR and an immediate source from a RAM source.
- **An indexed store burst that crosses X from 0xFE through 0x00.** It exposes a carry leaking into Y or a missed wrap.
- **Near branches to an immediate and to the accumulator.** Each delay slot writes a distinct output value and each skipped word writes a poisoned one, so a squashed slot or an extra executed word shows up on the output.
- **Two trampoline lookups in different pages.** The first offset is set before the call and the second is set inside the far jump's delay slot at offset 250. Each page holds a table built from a different formula, so a wrong page or offset stores a wrong byte.

// File: rtl/h8_pkg.sv
package h8_pkg;
    localparam int DW    = 8;
    localparam int PC_W  = 2 * DW;
    localparam int IW_W  = 2 * DW;
    localparam int OP_W  = 3;

    localparam logic [OP_W-1:0] OP_LD  = 3'd0;
    localparam logic [OP_W-1:0] OP_OR  = 3'd1;
    localparam logic [OP_W-1:0] OP_ST  = 3'd2;
    localparam logic [OP_W-1:0] OP_JMP = 3'd3;
    localparam logic [OP_W-1:0] OP_BRA = 3'd4;

    localparam logic [IW_W-1:0] WORD_NOP = 16'hE000;

    typedef enum logic [1:0] {DST_AC, DST_X, DST_Y, DST_OUT} dst_e;
    typedef enum logic [1:0] {SRC_IMM, SRC_RAM, SRC_AC, SRC_ZERO} src_e;

    typedef struct packed {
        logic          wr_reg;
        logic          use_or;
        logic          wr_ram;
        logic          jmp_far;
        logic          jmp_near;
        dst_e          dst;
        logic          idx_mode;
        src_e          src;
        logic [DW-1:0] imm;
    } dec_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [IW_W-1:0] ir;
        logic [DW-1:0]   ac;
        logic [DW-1:0]   x;
        logic [DW-1:0]   y;
        logic [DW-1:0]   outr;
    } core_t;
endpackage

// File: rtl/h8_decode.sv
module h8_decode
    import h8_pkg::*;
(
    input  logic [IW_W-1:0] ir,
    output dec_t            dec
);
    logic [OP_W-1:0] op;

    always_comb begin
        op           = ir[IW_W-1 -: OP_W];
        dec.wr_reg   = (op == OP_LD) || (op == OP_OR);
        dec.use_or   = (op == OP_OR);
        dec.wr_ram   = (op == OP_ST);
        dec.jmp_far  = (op == OP_JMP);
        dec.jmp_near = (op == OP_BRA);
        dec.dst      = dst_e'(ir[12:11]);
        dec.idx_mode = ir[10];
        dec.src      = src_e'(ir[9:8]);
        dec.imm      = ir[DW-1:0];
    end
endmodule

// File: rtl/h8_datapath.sv
module h8_datapath
    import h8_pkg::*;
(
    input  dec_t            dec,
    input  logic [DW-1:0]   ac,
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    input  logic [DW-1:0]   ram_rdata,
    output logic [PC_W-1:0] ram_addr,
    output logic [DW-1:0]   bus,
    output logic [DW-1:0]   alu,
    output logic            x_step
);
    logic active;

    always_comb begin
        ram_addr = dec.idx_mode ? {y, x} : {{DW{1'b0}}, dec.imm};
        unique case (dec.src)
            SRC_IMM: bus = dec.imm;
            SRC_RAM: bus = ram_rdata;
            SRC_AC:  bus = ac;
            default: bus = '0;
        endcase
        alu    = dec.use_or ? (bus | ac) : bus;
        active = dec.wr_reg | dec.wr_ram | dec.jmp_far | dec.jmp_near;
        x_step = active && dec.idx_mode && (dec.wr_ram || (dec.src == SRC_RAM));
    end
endmodule

// File: rtl/h8_pcunit.sv
module h8_pcunit
    import h8_pkg::*;
(
    input  dec_t            dec,
    input  logic [PC_W-1:0] pc_q,
    input  logic [DW-1:0]   y,
    input  logic [DW-1:0]   bus,
    output logic [PC_W-1:0] pc_d
);
    always_comb begin
        if (dec.jmp_far)
            pc_d = {y, bus};
        else if (dec.jmp_near)
            pc_d = {pc_q[PC_W-1:DW], bus};
        else
            pc_d = pc_q + 1'b1;
    end
endmodule

// File: rtl/h8_core.sv
module h8_core
    import h8_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PC_W-1:0] prog_addr,
    input  logic [IW_W-1:0] prog_data,
    output logic [PC_W-1:0] ram_addr,
    output logic [DW-1:0]   ram_wdata,
    output logic            ram_we,
    input  logic [DW-1:0]   ram_rdata,
    output logic [DW-1:0]   out_port
);
    core_t           cur_q, nxt_d;
    dec_t            dec;
    logic [DW-1:0]   dp_bus, dp_alu;
    logic            x_step;
    logic [PC_W-1:0] pc_next;

    h8_decode u_dec (.ir(cur_q.ir), .dec(dec));

    h8_datapath u_dp (
        .dec(dec), .ac(cur_q.ac), .x(cur_q.x), .y(cur_q.y),
        .ram_rdata(ram_rdata), .ram_addr(ram_addr),
        .bus(dp_bus), .alu(dp_alu), .x_step(x_step)
    );

    h8_pcunit u_pc (
        .dec(dec), .pc_q(cur_q.pc), .y(cur_q.y), .bus(dp_bus), .pc_d(pc_next)
    );

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.ir = prog_data;
        nxt_d.pc = pc_next;
        if (x_step)
            nxt_d.x = cur_q.x + 1'b1;
        if (dec.wr_reg) begin
            unique case (dec.dst)
                DST_AC:  nxt_d.ac   = dp_alu;
                DST_X:   nxt_d.x    = dp_alu;
                DST_Y:   nxt_d.y    = dp_alu;
                default: nxt_d.outr = dp_alu;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.pc   <= '0;
            cur_q.ir   <= WORD_NOP;
            cur_q.ac   <= '0;
            cur_q.x    <= '0;
            cur_q.y    <= '0;
            cur_q.outr <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign prog_addr = cur_q.pc;
    assign ram_wdata = dp_bus;
    assign ram_we    = dec.wr_ram;
    assign out_port  = cur_q.outr;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cur_q.pc == '0 && cur_q.ir == WORD_NOP && !ram_we));

    assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.jmp_far || dec.jmp_near) |=> cur_q.pc == $past(cur_q.pc) + 1'b1);

    assert_slot_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cur_q.ir == $past(prog_data));

    assert_store_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> cur_q.ir[15:13] == OP_ST);

    assert_x_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_step && !(dec.wr_reg && dec.dst == DST_X)) |=> cur_q.x == $past(cur_q.x) + 8'd1);

    assert_y_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (x_step && !(dec.wr_reg && dec.dst == DST_Y)) |=> $stable(cur_q.y));

    assert_near_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec.jmp_near |=> cur_q.pc == {$past(cur_q.pc[PC_W-1:DW]), $past(dp_bus)});

    assert_far_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dec.jmp_far |=> cur_q.pc == {$past(cur_q.y), $past(dp_bus)});
endmodule

// File: tb/h8_core_test.sv
module h8_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] prog_addr, prog_data, ram_addr;
    logic [7:0]  ram_wdata, ram_rdata, out_port;
    logic        ram_we;

    logic [15:0] rom   [0:1023];
    logic [7:0]  ram_d [0:1023];
    logic [7:0]  ram_m [0:1023];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    h8_core uut (
        .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_data(prog_data),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .ram_rdata(ram_rdata), .out_port(out_port)
    );

    assign prog_data = rom[prog_addr[9:0]];
    assign ram_rdata = ram_d[ram_addr[9:0]];
    always @(posedge clk) if (ram_we) ram_d[ram_addr[9:0]] <= ram_wdata;

    function automatic logic [15:0] enc(int op, int dst, int idx, int src, int imm);
        return {op[2:0], dst[1:0], idx[0], src[1:0], imm[7:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference model state
    logic [15:0] pc_m, ir_m;
    logic [7:0]  ac_m, x_m, y_m, out_m;
    bit saw_skip = 0, saw_slot = 0, saw_ret = 0, saw_tbl = 0;

    task automatic model_step();
        int op, dst, idx, src;
        logic [7:0] imm, opnd, res;
        logic [15:0] a, nxt;
        op = int'(ir_m[15:13]); dst = int'(ir_m[12:11]);
        idx = int'(ir_m[10]); src = int'(ir_m[9:8]); imm = ir_m[7:0];
        a = idx ? {y_m, x_m} : {8'h00, imm};
        case (src)
            0: opnd = imm;
            1: opnd = ram_m[a[9:0]];
            2: opnd = ac_m;
            default: opnd = 8'h00;
        endcase
        nxt = pc_m + 16'd1;
        if (op <= 4 && idx == 1 && (op == 2 || src == 1)) x_m = x_m + 8'd1;
        if (op == 0 || op == 1) begin
            res = (op == 1) ? (opnd | ac_m) : opnd;
            case (dst)
                0: ac_m = res;
                1: x_m = res;
                2: y_m = res;
                default: out_m = res;
            endcase
        end
        if (op == 2) ram_m[a[9:0]] = opnd;
        if (op == 3) nxt = {y_m, opnd};
        if (op == 4) nxt = {pc_m[15:8], opnd};
        ir_m = rom[pc_m[9:0]];
        pc_m = nxt;
    endtask

    task automatic compare();
        int op, idx;
        logic [15:0] a;
        logic [7:0] d;
        op = int'(ir_m[15:13]); idx = int'(ir_m[10]);
        a = idx ? {y_m, x_m} : {8'h00, ir_m[7:0]};
        case (int'(ir_m[9:8]))
            0: d = ir_m[7:0];
            1: d = ram_m[a[9:0]];
            2: d = ac_m;
            default: d = 8'h00;
        endcase
        chk(prog_addr == pc_m, "R2 prog_addr", {16'h0, prog_addr}, {16'h0, pc_m});
        chk(ram_we == (op == 2), "R5 ram_we", {31'h0, ram_we}, {31'h0, op == 2});
        if (op == 2 && ram_we) begin
            chk(ram_addr == a, "R5 ram_addr", {16'h0, ram_addr}, {16'h0, a});
            chk(ram_wdata == d, "R5 ram_wdata", {24'h0, ram_wdata}, {24'h0, d});
        end
        chk(out_port == out_m, "R3/R4 out_port", {24'h0, out_port}, {24'h0, out_m});
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            rom[i] = 16'hE000; ram_d[i] = 8'h00; ram_m[i] = 8'h00;
        end
        ram_d[10'h201] = 8'h44; ram_m[10'h201] = 8'h44;
        // straight-line code
        rom[16'h00] = enc(0, 0, 0, 0, 8'h5A);
        rom[16'h01] = enc(2, 0, 0, 2, 8'h10);
        rom[16'h02] = enc(1, 0, 0, 0, 8'h81);
        rom[16'h03] = enc(2, 0, 0, 2, 8'h11);
        rom[16'h04] = enc(0, 2, 0, 0, 8'h02);
        rom[16'h05] = enc(0, 1, 0, 0, 8'hFE);
        rom[16'h06] = enc(2, 0, 1, 0, 8'h11);
        rom[16'h07] = enc(2, 0, 1, 0, 8'h22);
        rom[16'h08] = enc(2, 0, 1, 0, 8'h33);
        rom[16'h09] = enc(0, 0, 1, 1, 8'h00);
        rom[16'h0A] = enc(1, 3, 0, 1, 8'h10);
        rom[16'h0B] = enc(4, 0, 0, 0, 8'h20);
        rom[16'h0C] = enc(0, 3, 0, 0, 8'h77);
        rom[16'h0D] = enc(0, 3, 0, 0, 8'h99);
        rom[16'h20] = enc(2, 0, 0, 2, 8'h12);
        rom[16'h21] = enc(0, 0, 0, 0, 8'h30);
        rom[16'h22] = enc(4, 0, 0, 2, 8'h00);
        rom[16'h23] = enc(0, 3, 0, 0, 8'h66);
        rom[16'h24] = enc(0, 3, 0, 0, 8'hEE);
        // first lookup: page 1, offset 0x42
        rom[16'h30] = enc(0, 2, 0, 0, 8'h01);
        rom[16'h31] = enc(0, 0, 0, 0, 8'h42);
        rom[16'h32] = enc(3, 0, 0, 0, 8'hFB);
        // second lookup: page 3, offset 250 set in the delay slot
        rom[16'h40] = enc(0, 0, 0, 0, 8'h05);
        rom[16'h41] = enc(0, 2, 0, 0, 8'h03);
        rom[16'h42] = enc(3, 0, 0, 0, 8'hFB);
        rom[16'h43] = enc(0, 0, 0, 0, 8'hFA);
        rom[16'h50] = enc(4, 0, 0, 0, 8'h50);
        for (int i = 0; i <= 250; i++) begin
            rom[10'h100 + i] = enc(0, 0, 0, 0, (i * 7 + 3) & 8'hFF);
            rom[10'h300 + i] = enc(0, 0, 0, 0, (i ^ 8'hA5) & 8'hFF);
        end
        rom[10'h1FB] = enc(4, 0, 0, 2, 0);
        rom[10'h1FC] = enc(4, 0, 0, 0, 8'hFD);
        rom[10'h1FD] = enc(0, 2, 0, 0, 8'h00);
        rom[10'h1FE] = enc(3, 0, 0, 0, 8'h40);
        rom[10'h1FF] = enc(2, 0, 0, 2, 8'h13);
        rom[10'h3FB] = enc(4, 0, 0, 2, 0);
        rom[10'h3FC] = enc(4, 0, 0, 0, 8'hFD);
        rom[10'h3FD] = enc(0, 2, 0, 0, 8'h00);
        rom[10'h3FE] = enc(3, 0, 0, 0, 8'h50);
        rom[10'h3FF] = enc(2, 0, 0, 2, 8'h14);

        pc_m = 16'h0; ir_m = 16'hE000; ac_m = 0; x_m = 0; y_m = 0; out_m = 0;
        repeat (3) @(negedge clk);
        chk(prog_addr == 16'h0, "R1 reset pc", {16'h0, prog_addr}, 32'h0);
        chk(out_port == 8'h0, "R1 reset out", {24'h0, out_port}, 32'h0);
        chk(!ram_we, "R1 reset we", {31'h0, ram_we}, 32'h0);
        rst_n = 1'b1;
        for (int c = 0; c < 150; c++) begin
            compare();
            if (out_port == 8'h99 || out_port == 8'hEE) saw_skip = 1;
            if (out_port == 8'h77) saw_slot = 1;
            if (prog_addr == 16'h0040) saw_ret = 1;
            if (prog_addr == 16'h0142) saw_tbl = 1;
            model_step();
            @(negedge clk);
        end
        chk(ram_d[10'h010] == 8'h5A, "R3 load imm", {24'h0, ram_d[10'h010]}, 32'h5A);
        chk(ram_d[10'h011] == 8'hDB, "R4 or imm", {24'h0, ram_d[10'h011]}, 32'hDB);
        chk(ram_d[10'h2FE] == 8'h11, "R5 indexed store", {24'h0, ram_d[10'h2FE]}, 32'h11);
        chk(ram_d[10'h2FF] == 8'h22, "R6 x step", {24'h0, ram_d[10'h2FF]}, 32'h22);
        chk(ram_d[10'h200] == 8'h33, "R6 x wrap y kept", {24'h0, ram_d[10'h200]}, 32'h33);
        chk(ram_d[10'h012] == 8'h44, "R6 indexed ram load", {24'h0, ram_d[10'h012]}, 32'h44);
        chk(saw_slot && !saw_skip, "R7 delay slot only", {31'h0, saw_skip}, 32'h0);
        chk(out_port == 8'h66, "R8 branch to ac slot", {24'h0, out_port}, 32'h66);
        chk(saw_ret, "R9 far jump return", {31'h0, saw_ret}, 32'h1);
        chk(saw_tbl, "R10 lookup fetch", {31'h0, saw_tbl}, 32'h1);
        chk(ram_d[10'h013] == 8'((8'h42 * 7 + 3) & 8'hFF), "R10 lookup page 1",
            {24'h0, ram_d[10'h013]}, 32'hD1);
        chk(ram_d[10'h014] == 8'(8'hFA ^ 8'hA5), "R10 lookup offset 250",
            {24'h0, ram_d[10'h014]}, 32'h5F);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule